// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the central control state machine of a multicycle 32-bit load/store processor core. Each instruction is spread over several clock cycles that share one ALU and one memory port. The sequencer holds the current step of the instruction and drives the select and enable lines of the datapath for that step. It handles five instruction classes: register-register ALU operations, word load, word store, branch-if-equal and jump. A fetch step and a decode step are common to all of them.

The datapath shows the 6-bit major opcode from its instruction register on the `opcode` input. The sequencer reads it in the decode cycle only and keeps the resulting instruction class in its own state. After that the instruction register may change without effect. Every control output comes from a register and matches the step the machine is in. The datapath sees clean levels from the clock edge onward. Reset is synchronous, active high, and puts the machine into fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows the fetch controls. The first edge after `rst` falls moves the machine to decode. Reset taken in any step of any instruction abandons that instruction and enters fetch.
- R2: Fetch drives `mem_rd_en`=1, `ir_latch_en`=1, `addr_from_alu`=0, `alu_a_sel`=0, `alu_b_sel`=1 (constant four), `alu_func`=0 (add), `pc_load`=1 and `pc_next_sel`=0 (live ALU result). All other outputs are 0.
- R3: Decode follows every fetch and drives `alu_a_sel`=0, `alu_b_sel`=3 (shifted offset) and `alu_func`=0. Every memory, register-file, PC and instruction-register enable is low.
- R4: Only the opcode present during decode selects the path. 0x00 is the ALU class, 0x23 is load, 0x2B is store, 0x04 is branch and 0x02 is jump. Any other value returns to fetch on the next edge. Opcode values in other cycles have no effect.
- R5: For load and store, the step after decode drives `alu_a_sel`=1, `alu_b_sel`=2 (sign-extended offset) and `alu_func`=0, with all enables low.
- R6: A load then passes through a memory-read step (`mem_rd_en`=1, `addr_from_alu`=1) and a write-back step (`rf_wr_en`=1, `wb_from_mem`=1, `dest_from_rd`=0), then returns to fetch. The whole load takes 5 cycles.
- R7: A store then passes through one memory-write step (`mem_wr_en`=1, `addr_from_alu`=1, register-file and PC enables low), then returns to fetch. The whole store takes 4 cycles.
- R8: An ALU-class instruction passes through an execute step (`alu_a_sel`=1, `alu_b_sel`=0, `alu_func`=2 meaning "decode the function field") and a completion step (`rf_wr_en`=1, `dest_from_rd`=1, `wb_from_mem`=0), then returns to fetch. It takes 4 cycles.
- R9: A branch passes through one step with `alu_a_sel`=1, `alu_b_sel`=0, `alu_func`=1 (subtract), `pc_load_if_zero`=1 and `pc_next_sel`=1 (held ALU result), then returns to fetch. It takes 3 cycles.
- R10: A jump passes through one step with `pc_load`=1 and `pc_next_sel`=2 (jump target), then returns to fetch. It takes 3 cycles.
- R11: `ir_latch_en` is high only in fetch, and `mem_rd_en` and `mem_wr_en` are never high together. Any output not named for a step is 0 in that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode field from the instruction register |
| addr_from_alu | output | 1 | Memory address source: 0 = PC, 1 = held ALU result |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| ir_latch_en | output | 1 | Instruction register load enable |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 0 = register B, 1 = four, 2 = offset, 3 = offset shifted left by two |
| alu_func | output | 2 | ALU operation: 0 = add, 1 = subtract, 2 = from function field |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_zero | output | 1 | PC write qualified by the ALU zero flag |
| pc_next_sel | output | 2 | PC source: 0 = ALU result, 1 = held ALU result, 2 = jump target |
| dest_from_rd | output | 1 | Destination register field: 0 = rt, 1 = rd |
| rf_wr_en | output | 1 | Register file write enable |
| wb_from_mem | output | 1 | Write-back data: 0 = held ALU result, 1 = memory data register |

## Verification
Reset can arrive in the same cycle as any step of an instruction, and also in the same cycle as the decision that decode takes on the opcode. The bench asserts reset at random points inside randomly chosen instructions. It expects the fetch controls on the very next cycle and a clean restart after release. A second pair that coincides is the opcode decision and a change of the opcode input. The bench drives random values in every cycle except decode and judges each step against the path fixed by the decode-cycle opcode.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int SEL_W = 2;

    // Step of the instruction sequence
    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_LOAD_MEM  = 4'd3,
        ST_LOAD_WB   = 4'd4,
        ST_STORE_MEM = 4'd5,
        ST_ALU_EXEC  = 4'd6,
        ST_ALU_DONE  = 4'd7,
        ST_BRANCH    = 4'd8,
        ST_JUMP      = 4'd9
    } state_e;

    // Instruction class taken from the opcode in decode
    typedef enum logic [2:0] {
        CL_ALU    = 3'd0,
        CL_LOAD   = 3'd1,
        CL_STORE  = 3'd2,
        CL_BRANCH = 3'd3,
        CL_JUMP   = 3'd4,
        CL_NONE   = 3'd5
    } class_e;

    // Operand B selects
    localparam logic [SEL_W-1:0] B_REG    = 2'd0;
    localparam logic [SEL_W-1:0] B_FOUR   = 2'd1;
    localparam logic [SEL_W-1:0] B_IMM    = 2'd2;
    localparam logic [SEL_W-1:0] B_IMM_SH = 2'd3;

    // ALU operation codes
    localparam logic [SEL_W-1:0] FN_ADD   = 2'd0;
    localparam logic [SEL_W-1:0] FN_SUB   = 2'd1;
    localparam logic [SEL_W-1:0] FN_FIELD = 2'd2;

    // PC source selects
    localparam logic [SEL_W-1:0] PC_ALU  = 2'd0;
    localparam logic [SEL_W-1:0] PC_HELD = 2'd1;
    localparam logic [SEL_W-1:0] PC_JUMP = 2'd2;

    typedef struct packed {
        logic             addr_from_alu;
        logic             mem_rd_en;
        logic             mem_wr_en;
        logic             ir_latch_en;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_func;
        logic             pc_load;
        logic             pc_load_if_zero;
        logic [SEL_W-1:0] pc_next_sel;
        logic             dest_from_rd;
        logic             rf_wr_en;
        logic             wb_from_mem;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
    import mc_ctrl_pkg::*;
#(
    parameter int              OPW       = OPC_W,
    parameter logic [OPW-1:0]  OP_ALU    = 6'h00,
    parameter logic [OPW-1:0]  OP_LOAD   = 6'h23,
    parameter logic [OPW-1:0]  OP_STORE  = 6'h2B,
    parameter logic [OPW-1:0]  OP_BRANCH = 6'h04,
    parameter logic [OPW-1:0]  OP_JUMP   = 6'h02
) (
    input  logic [OPW-1:0] opcode,
    output class_e         cls
);

    always_comb begin
        if (opcode == OP_ALU)         cls = CL_ALU;
        else if (opcode == OP_LOAD)   cls = CL_LOAD;
        else if (opcode == OP_STORE)  cls = CL_STORE;
        else if (opcode == OP_BRANCH) cls = CL_BRANCH;
        else if (opcode == OP_JUMP)   cls = CL_JUMP;
        else                          cls = CL_NONE;
    end

endmodule

// File: rtl/mc_state_seq.sv
module mc_state_seq
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  class_e cls_in,
    output state_e state_q,
    output state_e state_d
);

    typedef struct packed {
        state_e state;
        class_e cls;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_FETCH: seq_d.state = ST_DECODE;
            ST_DECODE: begin
                seq_d.cls = cls_in;
                case (cls_in)
                    CL_ALU:              seq_d.state = ST_ALU_EXEC;
                    CL_LOAD, CL_STORE:   seq_d.state = ST_MEM_ADDR;
                    CL_BRANCH:           seq_d.state = ST_BRANCH;
                    CL_JUMP:             seq_d.state = ST_JUMP;
                    default:             seq_d.state = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR:
                seq_d.state = (seq_q.cls == CL_LOAD) ? ST_LOAD_MEM : ST_STORE_MEM;
            ST_LOAD_MEM: seq_d.state = ST_LOAD_WB;
            ST_ALU_EXEC: seq_d.state = ST_ALU_DONE;
            default:     seq_d.state = ST_FETCH;
        endcase
        if (rst) begin
            seq_d.state = ST_FETCH;
            seq_d.cls   = CL_NONE;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign state_q = seq_q.state;
    assign state_d = seq_d.state;

    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        seq_q.state == ST_FETCH |=> seq_q.state == ST_DECODE); // R3
    AST_LOAD_WB_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        seq_q.state == ST_LOAD_MEM |=> seq_q.state == ST_LOAD_WB); // R6
    AST_ALU_DONE_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        seq_q.state == ST_ALU_EXEC |=> seq_q.state == ST_ALU_DONE); // R8
    AST_TERMINAL_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == ST_LOAD_WB || seq_q.state == ST_STORE_MEM ||
         seq_q.state == ST_ALU_DONE || seq_q.state == ST_BRANCH ||
         seq_q.state == ST_JUMP) |=> seq_q.state == ST_FETCH); // R7
    AST_CLASS_HELD: assert property (@(posedge clk) disable iff (rst)
        seq_q.state != ST_DECODE |=> $stable(seq_q.cls)); // R4

endmodule

// File: rtl/mc_ctrl_regs.sv
module mc_ctrl_regs
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e state_d,
    output ctrl_t  ctrl_q
);

    ctrl_t ctrl_d;

    function automatic ctrl_t ctrl_for(state_e st);
        ctrl_t c;
        c = CTRL_IDLE;
        case (st)
            ST_FETCH: begin
                c.mem_rd_en   = 1'b1;
                c.ir_latch_en = 1'b1;
                c.alu_b_sel   = B_FOUR;
                c.alu_func    = FN_ADD;
                c.pc_load     = 1'b1;
                c.pc_next_sel = PC_ALU;
            end
            ST_DECODE: begin
                c.alu_b_sel = B_IMM_SH;
                c.alu_func  = FN_ADD;
            end
            ST_MEM_ADDR: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = B_IMM;
                c.alu_func  = FN_ADD;
            end
            ST_LOAD_MEM: begin
                c.mem_rd_en     = 1'b1;
                c.addr_from_alu = 1'b1;
            end
            ST_LOAD_WB: begin
                c.rf_wr_en    = 1'b1;
                c.wb_from_mem = 1'b1;
            end
            ST_STORE_MEM: begin
                c.mem_wr_en     = 1'b1;
                c.addr_from_alu = 1'b1;
            end
            ST_ALU_EXEC: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = B_REG;
                c.alu_func  = FN_FIELD;
            end
            ST_ALU_DONE: begin
                c.rf_wr_en     = 1'b1;
                c.dest_from_rd = 1'b1;
            end
            ST_BRANCH: begin
                c.alu_a_sel       = 1'b1;
                c.alu_b_sel       = B_REG;
                c.alu_func        = FN_SUB;
                c.pc_load_if_zero = 1'b1;
                c.pc_next_sel     = PC_HELD;
            end
            ST_JUMP: begin
                c.pc_load     = 1'b1;
                c.pc_next_sel = PC_JUMP;
            end
            default: c = CTRL_IDLE;
        endcase
        return c;
    endfunction

    always_comb begin
        ctrl_d = ctrl_for(state_d);
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_q.mem_rd_en && ctrl_q.mem_wr_en)); // R11
    AST_REGWR_QUIET_MEM: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rf_wr_en |-> !ctrl_q.mem_wr_en && !ctrl_q.pc_load); // R8

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int              OPW       = OPC_W,
    parameter logic [OPW-1:0]  OP_ALU    = 6'h00,
    parameter logic [OPW-1:0]  OP_LOAD   = 6'h23,
    parameter logic [OPW-1:0]  OP_STORE  = 6'h2B,
    parameter logic [OPW-1:0]  OP_BRANCH = 6'h04,
    parameter logic [OPW-1:0]  OP_JUMP   = 6'h02
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   opcode,
    output logic             addr_from_alu,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic             ir_latch_en,
    output logic             alu_a_sel,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic [SEL_W-1:0] alu_func,
    output logic             pc_load,
    output logic             pc_load_if_zero,
    output logic [SEL_W-1:0] pc_next_sel,
    output logic             dest_from_rd,
    output logic             rf_wr_en,
    output logic             wb_from_mem
);

    class_e cls;
    state_e state_q;
    state_e state_d;
    ctrl_t  ctrl_q;

    mc_op_classify #(
        .OPW(OPW), .OP_ALU(OP_ALU), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
        .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
    ) u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_state_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .cls_in  (cls),
        .state_q (state_q),
        .state_d (state_d)
    );

    mc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .ctrl_q  (ctrl_q)
    );

    assign addr_from_alu   = ctrl_q.addr_from_alu;
    assign mem_rd_en       = ctrl_q.mem_rd_en;
    assign mem_wr_en       = ctrl_q.mem_wr_en;
    assign ir_latch_en     = ctrl_q.ir_latch_en;
    assign alu_a_sel       = ctrl_q.alu_a_sel;
    assign alu_b_sel       = ctrl_q.alu_b_sel;
    assign alu_func        = ctrl_q.alu_func;
    assign pc_load         = ctrl_q.pc_load;
    assign pc_load_if_zero = ctrl_q.pc_load_if_zero;
    assign pc_next_sel     = ctrl_q.pc_next_sel;
    assign dest_from_rd    = ctrl_q.dest_from_rd;
    assign rf_wr_en        = ctrl_q.rf_wr_en;
    assign wb_from_mem     = ctrl_q.wb_from_mem;

    AST_IR_LATCH_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        ir_latch_en |-> state_q == ST_FETCH); // R11
    AST_COND_PC_IN_BRANCH: assert property (@(posedge clk) disable iff (rst)
        pc_load_if_zero |-> state_q == ST_BRANCH); // R9
    AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_q == ST_FETCH && ir_latch_en); // R1

endmodule

// File: tb/mc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;

    localparam int PERIOD = 20;
    localparam int N_INSTR = 400;

    // bench-local step codes
    localparam int P_F = 0, P_D = 1, P_A = 2, P_LM = 3, P_LW = 4,
                   P_SM = 5, P_RE = 6, P_RD = 7, P_BR = 8, P_J = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       addr_from_alu, mem_rd_en, mem_wr_en, ir_latch_en, alu_a_sel;
    logic [1:0] alu_b_sel, alu_func, pc_next_sel;
    logic       pc_load, pc_load_if_zero, dest_from_rd, rf_wr_en, wb_from_mem;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst(rst), .opcode(opcode),
        .addr_from_alu(addr_from_alu), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .ir_latch_en(ir_latch_en), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_func(alu_func), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .pc_next_sel(pc_next_sel), .dest_from_rd(dest_from_rd), .rf_wr_en(rf_wr_en),
        .wb_from_mem(wb_from_mem)
    );

    function automatic logic [15:0] pack(input logic iod, rd, wr, ir, a,
                                         input logic [1:0] b, fn,
                                         input logic pl, pz,
                                         input logic [1:0] ps,
                                         input logic dst, rw, wbm);
        return {iod, rd, wr, ir, a, b, fn, pl, pz, ps, dst, rw, wbm};
    endfunction

    function automatic logic [15:0] expect_of(input int p);
        case (p)
            P_F:  return pack(0,1,0,1,0,2'd1,2'd0,1,0,2'd0,0,0,0);
            P_D:  return pack(0,0,0,0,0,2'd3,2'd0,0,0,2'd0,0,0,0);
            P_A:  return pack(0,0,0,0,1,2'd2,2'd0,0,0,2'd0,0,0,0);
            P_LM: return pack(1,1,0,0,0,2'd0,2'd0,0,0,2'd0,0,0,0);
            P_LW: return pack(0,0,0,0,0,2'd0,2'd0,0,0,2'd0,0,1,1);
            P_SM: return pack(1,0,1,0,0,2'd0,2'd0,0,0,2'd0,0,0,0);
            P_RE: return pack(0,0,0,0,1,2'd0,2'd2,0,0,2'd0,0,0,0);
            P_RD: return pack(0,0,0,0,0,2'd0,2'd0,0,0,2'd0,1,1,0);
            P_BR: return pack(0,0,0,0,1,2'd0,2'd1,0,1,2'd1,0,0,0);
            P_J:  return pack(0,0,0,0,0,2'd0,2'd0,1,0,2'd2,0,0,0);
            default: return 16'h0;
        endcase
    endfunction

    function automatic int class_of(input logic [5:0] op);
        case (op)
            6'h00: return 0;
            6'h23: return 1;
            6'h2B: return 2;
            6'h04: return 3;
            6'h02: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int steps_of(input logic [5:0] op);
        case (class_of(op))
            0: return 4;
            1: return 5;
            2: return 4;
            3: return 3;
            4: return 3;
            default: return 2;
        endcase
    endfunction

    // step list after fetch: decode ... fetch
    function automatic int phase_at(input logic [5:0] op, input int i);
        int c;
        c = class_of(op);
        if (i == 0) return P_D;
        if (i == steps_of(op) - 1) return P_F;
        case (c)
            0: return (i == 1) ? P_RE : P_RD;
            1: return (i == 1) ? P_A : ((i == 2) ? P_LM : P_LW);
            2: return (i == 1) ? P_A : P_SM;
            3: return P_BR;
            default: return P_J;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] op, input int i);
        int p;
        p = phase_at(op, i);
        if (i == 1) return "R4";
        case (p)
            P_F:  return "R2";
            P_D:  return "R3";
            P_A:  return "R5";
            P_LM, P_LW: return "R6";
            P_SM: return "R7";
            P_RE, P_RD: return "R8";
            P_BR: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] actual();
        return {addr_from_alu, mem_rd_en, mem_wr_en, ir_latch_en, alu_a_sel,
                alu_b_sel, alu_func, pc_load, pc_load_if_zero, pc_next_sel,
                dest_from_rd, rf_wr_en, wb_from_mem};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic run_instr(input logic [5:0] op, input int rst_at);
        int n;
        n = steps_of(op);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            opcode = (i == 0) ? op : 6'($urandom);
            check(tag_of(op, i), actual(), expect_of(phase_at(op, i)));
            // R11: read and write enables never together
            check("R11", {15'd0, mem_rd_en & mem_wr_en}, 16'd0);
            if (i == rst_at && i != n - 1) begin
                rst = 1'b1;
                @(posedge clk);
                @(negedge clk);
                check("R1", actual(), expect_of(P_F));
                rst = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        logic [5:0] legal [5];
        legal[0] = 6'h00; legal[1] = 6'h23; legal[2] = 6'h2B;
        legal[3] = 6'h04; legal[4] = 6'h02;
        void'($urandom(32'd20240611));

        repeat (3) begin
            @(negedge clk);
            opcode = 6'($urandom);
            check("R1", actual(), expect_of(P_F));
        end
        rst = 1'b0;

        // directed: each class, then unknown opcodes at the edges of the range
        for (int k = 0; k < 5; k++) run_instr(legal[k], -1);
        run_instr(6'h3F, -1);
        run_instr(6'h01, -1);
        run_instr(6'h23, 2);
        run_instr(6'h00, 0);

        for (int k = 0; k < N_INSTR; k++) begin
            logic [5:0] op;
            int ra;
            op = ($urandom % 5 != 0) ? legal[$urandom % 5] : 6'($urandom);
            ra = ($urandom % 8 == 0) ? int'($urandom % 5) : -1;
            run_instr(op, ra);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule